// File: doc/BRIEF.md
# Serial NOR Page-Program Write Sequencer

This block turns one write request into the full sequence of byte-level transactions that programs a serial NOR flash. A request carries a start address and a byte count, and the data follows on a valid/ready stream. The block cuts the data into chunks that never run past the end of a 256-byte program page. Each chunk goes through the same cycle: a status poll until the flash is idle, a write-enable transaction, the program transaction (opcode, address, data) and a write-disable transaction.

The block drives a byte-level SPI master. Each byte it offers says whether the chip select closes after it, and whether one byte is read back before the select closes. A two-bit address mode picks one of four schemes. In fixed 3-byte mode the address is always 3 bytes. In fixed 4-byte mode it is always 4 bytes. In mixed mode a 4-byte address is used, inside an enter/exit bracket, only when the write ends at or above 16 MiB. Mixed-with-dies mode adds a second die above 32 MiB. A quad-program option changes the opcode and forces the 4-byte bracket. Once the final transaction has been accepted, the block pulses `done`. A flash that stays busy for too long ends the request with `done` and `err` together.

Top module: `spi_nor_page_writer`

## Requirements
- R1: A chunk starting at address A with N bytes left holds min(256 - (A mod 256), N) data bytes. Its last data byte carries `m_last`=1, so no program transaction crosses a 256-byte page.
- R2: Write enable and every mode or die command are each preceded by a status poll. A poll is byte 0x05 with `m_rd`=1 and `m_last`=1. A returned status with bit 0 set repeats the poll, and bit 0 clear lets the sequence go on. All other status bits are ignored.
- R3: Each chunk is three transactions in this order: 0x06 (last), then the program header followed by the data, then 0x04 (last). The 0x04 is offered in the cycle right after the last data byte is accepted.
- R4: The program opcode is 0x02. When `cfg_quad`=1 it is 0x32, with a 4-byte address.
- R5: `cfg_amode` encodes 0 = 3-byte, 1 = fixed 4-byte, 2 = mixed, 3 = mixed with dies. The address is 4 bytes when the mode is 1, or when quad is set, or when the mode is 2 or 3 and the segment's last address is at or above 0x1000000. Otherwise it is 3 bytes. Address bytes are sent most significant first.
- R6: In mode 2 or 3, a segment whose last address is at or above 0x1000000 is bracketed by 0xB7 before its first chunk and 0xE9 after its last chunk. Quad also brings the bracket. Mode 1 has no bracket.
- R7: In mode 3, a request that crosses 0x2000000 is split there into two segments. The upper segment is preceded by 0xC2 0x01, is followed by 0xC2 0x00, and uses addresses reduced by 0x2000000.
- R8: A request with a length of zero produces a one-cycle `done` in the next cycle, with `err`=0 and no SPI byte.
- R9: `wr_ready` is high only while data bytes are being forwarded. While it is high it equals `m_ready`, and `wr_data` appears on `m_byte`.
- R10: `req_ready` is high only when the block is idle, and no byte is offered while it is idle. `done` pulses for one cycle with `err`=0 once the final byte of a request has been accepted.
- R11: After POLL_MAX busy status replies in a row, `done` and `err` pulse together. The block returns to idle and offers no further byte.
- R12: A byte offered without `m_ready`, outside the data phase, stays the same until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Block idle, request accepted |
| req_addr | input | 32 | Start byte address |
| req_len | input | LEN_W | Byte count |
| cfg_amode | input | 2 | Address scheme (see R5) |
| cfg_quad | input | 1 | Use quad program opcode |
| wr_valid | input | 1 | Write data present |
| wr_ready | output | 1 | Write data taken |
| wr_data | input | 8 | Write data byte |
| m_valid | output | 1 | Byte offered to SPI master |
| m_ready | input | 1 | SPI master takes the byte |
| m_byte | output | 8 | Byte to shift out |
| m_last | output | 1 | Chip select closes after this byte (or its read-back) |
| m_rd | output | 1 | Read one byte back after this one |
| r_valid | input | 1 | Read-back byte present |
| r_byte | input | 8 | Read-back status byte |
| done | output | 1 | Request finished (one cycle) |
| err | output | 1 | Request aborted on poll timeout (with done) |

## Verification
Most internal slips show up in the byte stream within one accepted byte. A wrong chunk counter, a missed page wrap or a stale address register gives a misplaced `m_last`, a wrong address byte, or a 0x04 where data was due. A wrong phase register shows up as a missing or extra poll, or a bracket or die command in the wrong place. A fault in segment setup changes the address width or the die command before the first chunk starts, and a fault in poll counting moves the `err` pulse by whole poll rounds. The bench compares every accepted byte, with its last and read flags, against a behavioural model of the sequence, so these faults fail in the cycle where they appear.

// File: rtl/spi_nor_page_writer.sv
module spi_nor_page_writer #(
  parameter int          LEN_W     = 16,
  parameter int          PAGE_BITS = 8,
  parameter int          POLL_MAX  = 4096,
  parameter logic [31:0] WIDE_BASE = 32'h0100_0000,
  parameter logic [31:0] DIE_BASE  = 32'h0200_0000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [31:0]      req_addr,
  input  logic [LEN_W-1:0] req_len,
  input  logic [1:0]       cfg_amode,
  input  logic             cfg_quad,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [7:0]       wr_data,
  output logic             m_valid,
  input  logic             m_ready,
  output logic [7:0]       m_byte,
  output logic             m_last,
  output logic             m_rd,
  input  logic             r_valid,
  input  logic [7:0]       r_byte,
  output logic             done,
  output logic             err
);
  localparam int CW   = PAGE_BITS + 1;
  localparam int PW   = $clog2(POLL_MAX + 1);
  localparam int PAGE = 1 << PAGE_BITS;

  typedef enum logic [2:0] {ST_IDLE, ST_SEG, ST_POLL, ST_PRSP, ST_CMD, ST_HDR, ST_DATA, ST_WRDI} st_t;
  typedef enum logic [2:0] {PH_DSEL, PH_EN4, PH_WREN, PH_EX4, PH_DDSEL} ph_t;

  st_t             st;
  ph_t             ph;
  logic [31:0]     base_q, cur;
  logic [LEN_W-1:0] len_q, rem;
  logic [CW-1:0]   cnt;
  logic [2:0]      bidx;
  logic [PW-1:0]   pcnt;
  logic [1:0]      am_q;
  logic            quad_q, hi_q, br_q, wide_q, done_q, err_q;

  logic [32:0]     req_end, seg_end;
  logic            split, seg_hi, seg_br;
  logic [LEN_W-1:0] seg_len;
  logic [31:0]     seg_loc;
  logic [CW-1:0]   page_left, chunk;
  logic [2:0]      cmd_n, hdr_n, asel;
  logic [7:0]      cmd_op, addr_byte;
  logic            hs, cmd_end;

  assign req_end   = {1'b0, base_q} + 33'(len_q) - 33'd1;
  assign split     = (am_q == 2'd3) && (base_q < DIE_BASE) && (req_end >= {1'b0, DIE_BASE});
  assign seg_len   = split ? LEN_W'(DIE_BASE - base_q) : len_q;
  assign seg_hi    = (am_q == 2'd3) && (base_q >= DIE_BASE);
  assign seg_loc   = seg_hi ? (base_q - DIE_BASE) : base_q;
  assign seg_end   = {1'b0, seg_loc} + 33'(seg_len) - 33'd1;
  assign seg_br    = quad_q || (am_q[1] && (seg_end >= {1'b0, WIDE_BASE}));

  assign page_left = CW'(PAGE) - CW'(cur[PAGE_BITS-1:0]);
  assign chunk     = (rem < LEN_W'(page_left)) ? CW'(rem) : page_left;

  assign cmd_n     = (ph == PH_DSEL || ph == PH_DDSEL) ? 3'd2 : 3'd1;
  assign hdr_n     = wide_q ? 3'd5 : 3'd4;
  assign asel      = hdr_n - 3'd1 - bidx;
  assign addr_byte = 8'(cur >> {asel, 3'b000});
  assign cmd_end   = (bidx == cmd_n - 3'd1);

  always_comb begin
    case (ph)
      PH_DSEL, PH_DDSEL: cmd_op = 8'hC2;
      PH_EN4:            cmd_op = 8'hB7;
      PH_EX4:            cmd_op = 8'hE9;
      default:           cmd_op = 8'h06;
    endcase
  end

  always_comb begin
    m_valid = 1'b0;
    m_byte  = 8'h00;
    m_last  = 1'b0;
    m_rd    = 1'b0;
    case (st)
      ST_POLL: begin m_valid = 1'b1; m_byte = 8'h05; m_last = 1'b1; m_rd = 1'b1; end
      ST_CMD: begin
        m_valid = 1'b1;
        m_last  = cmd_end;
        m_byte  = (bidx == 3'd0) ? cmd_op : ((ph == PH_DSEL) ? 8'h01 : 8'h00);
      end
      ST_HDR: begin
        m_valid = 1'b1;
        m_byte  = (bidx == 3'd0) ? (quad_q ? 8'h32 : 8'h02) : addr_byte;
      end
      ST_DATA: begin m_valid = wr_valid; m_byte = wr_data; m_last = (cnt == CW'(1)); end
      ST_WRDI: begin m_valid = 1'b1; m_byte = 8'h04; m_last = 1'b1; end
      default: ;
    endcase
  end

  assign hs        = m_valid && m_ready;
  assign wr_ready  = (st == ST_DATA) && m_ready;
  assign req_ready = (st == ST_IDLE);
  assign done      = done_q;
  assign err       = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_IDLE; ph <= PH_WREN;
      base_q <= '0; cur <= '0; len_q <= '0; rem <= '0; cnt <= '0;
      bidx <= '0; pcnt <= '0; am_q <= '0;
      quad_q <= 1'b0; hi_q <= 1'b0; br_q <= 1'b0; wide_q <= 1'b0;
      done_q <= 1'b0; err_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      case (st)
        ST_IDLE: if (req_valid) begin
          base_q <= req_addr; len_q <= req_len; am_q <= cfg_amode; quad_q <= cfg_quad;
          if (req_len == '0) done_q <= 1'b1;
          else st <= ST_SEG;
        end
        ST_SEG: begin
          hi_q   <= seg_hi;
          br_q   <= seg_br;
          wide_q <= seg_br || (am_q == 2'd1);
          cur    <= seg_loc;
          rem    <= seg_len;
          base_q <= base_q + 32'(seg_len);
          len_q  <= len_q - seg_len;
          pcnt   <= '0;
          ph     <= seg_hi ? PH_DSEL : (seg_br ? PH_EN4 : PH_WREN);
          st     <= ST_POLL;
        end
        ST_POLL: if (hs) st <= ST_PRSP;
        ST_PRSP: if (r_valid) begin
          if (!r_byte[0]) begin
            pcnt <= '0; bidx <= '0; st <= ST_CMD;
          end else if (pcnt == PW'(POLL_MAX - 1)) begin
            pcnt <= '0; done_q <= 1'b1; err_q <= 1'b1; st <= ST_IDLE;
          end else begin
            pcnt <= pcnt + PW'(1); st <= ST_POLL;
          end
        end
        ST_CMD: if (hs) begin
          if (!cmd_end) bidx <= bidx + 3'd1;
          else begin
            case (ph)
              PH_DSEL: begin ph <= br_q ? PH_EN4 : PH_WREN; st <= ST_POLL; end
              PH_EN4:  begin ph <= PH_WREN; st <= ST_POLL; end
              PH_WREN: begin bidx <= '0; cnt <= chunk; st <= ST_HDR; end
              PH_EX4: begin
                if (hi_q) begin ph <= PH_DDSEL; st <= ST_POLL; end
                else if (len_q != '0) st <= ST_SEG;
                else begin done_q <= 1'b1; st <= ST_IDLE; end
              end
              default: begin
                if (len_q != '0) st <= ST_SEG;
                else begin done_q <= 1'b1; st <= ST_IDLE; end
              end
            endcase
          end
        end
        ST_HDR: if (hs) begin
          if (bidx == hdr_n - 3'd1) st <= ST_DATA;
          else bidx <= bidx + 3'd1;
        end
        ST_DATA: if (hs) begin
          cur <= cur + 32'd1;
          rem <= rem - LEN_W'(1);
          cnt <= cnt - CW'(1);
          if (cnt == CW'(1)) st <= ST_WRDI;
        end
        ST_WRDI: if (hs) begin
          if (rem != '0) begin ph <= PH_WREN; st <= ST_POLL; end
          else if (br_q) begin ph <= PH_EX4; st <= ST_POLL; end
          else if (hi_q) begin ph <= PH_DDSEL; st <= ST_POLL; end
          else if (len_q != '0) st <= ST_SEG;
          else begin done_q <= 1'b1; st <= ST_IDLE; end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  AST_PAGE_END_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DATA && wr_valid && m_ready && (&cur[PAGE_BITS-1:0])) |-> m_last); // R1
  AST_POLL_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && m_rd) |-> (m_byte == 8'h05 && m_last)); // R2
  AST_WRDI_AFTER_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DATA && wr_valid && m_ready && m_last) |=> (m_valid && m_byte == 8'h04 && m_last)); // R3
  AST_ZERO_LEN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_len == '0) |=> (done && !err && !m_valid)); // R8
  AST_DATA_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> (m_ready && !m_rd && !req_ready)); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!m_valid && !wr_ready)); // R10
  AST_ERR_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (done && $past(r_valid && r_byte[0]))); // R11
  AST_HOLD_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready && st != ST_DATA) |=> (m_valid && $stable(m_byte) && $stable(m_last))); // R12
endmodule

// File: tb/spi_nor_page_writer_bench.sv
module spi_nor_page_writer_bench;
  localparam int  PM   = 6;
  localparam int  BUSY = 2;
  localparam longint WIDE = 64'h0100_0000;
  localparam longint DIE  = 64'h0200_0000;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [31:0] req_addr = '0;
  logic [15:0] req_len = '0;
  logic [1:0] cfg_amode = '0;
  logic cfg_quad = 1'b0;
  logic wr_valid = 1'b0, wr_ready;
  logic [7:0] wr_data = '0;
  logic m_valid, m_ready = 1'b0, m_last, m_rd;
  logic [7:0] m_byte;
  logic r_valid = 1'b0;
  logic [7:0] r_byte = '0;
  logic done, err;

  spi_nor_page_writer #(.LEN_W(16), .PAGE_BITS(8), .POLL_MAX(PM)) u_spi_nor_page_writer (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len), .cfg_amode(cfg_amode), .cfg_quad(cfg_quad),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .m_valid(m_valid), .m_ready(m_ready), .m_byte(m_byte), .m_last(m_last), .m_rd(m_rd),
    .r_valid(r_valid), .r_byte(r_byte), .done(done), .err(err));

  int errs = 0, checks = 0, cyc = 0;
  logic [10:0] exp_q[$];
  string tag_q[$];
  int mbusy = 0, fbusy = 0, rsp_cd = 0, didx = 0, kidx = 0;
  bit stuck = 1'b0, exp_err = 1'b0, done_seen = 1'b0;
  logic [31:0] lfsr = 32'hACE1_2357;

  function automatic logic [7:0] dat(int i);
    return 8'((i * 37 + 11) ^ (i >> 3));
  endfunction

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  task automatic push(logic [7:0] b, bit last, bit rd, bit isd, string tag);
    exp_q.push_back({isd, rd, last, b});
    tag_q.push_back(tag);
  endtask

  task automatic mpoll();
    repeat (mbusy + 1) push(8'h05, 1, 1, 0, "R2");
    mbusy = 0;
  endtask

  // behavioural model of the expected byte stream
  task automatic gen(longint a, int len, int am, bit q);
    longint base = a, seglen, loc, endl, ca;
    int left = len, rem, n;
    bit hi, br, wide;
    while (left > 0) begin
      seglen = left;
      if (am == 3 && base < DIE && base + left - 1 >= DIE) seglen = DIE - base;
      hi = (am == 3 && base >= DIE);
      loc = hi ? base - DIE : base;
      endl = loc + seglen - 1;
      br = q || (am >= 2 && endl >= WIDE);
      wide = br || am == 1;
      if (hi) begin mpoll(); push(8'hC2, 0, 0, 0, "R7"); push(8'h01, 1, 0, 0, "R7"); end
      if (br) begin mpoll(); push(8'hB7, 1, 0, 0, "R6"); end
      rem = int'(seglen); ca = loc;
      while (rem > 0) begin
        mpoll();
        push(8'h06, 1, 0, 0, "R3");
        push(q ? 8'h32 : 8'h02, 0, 0, 0, "R4");
        if (wide) push(8'(ca >> 24), 0, 0, 0, "R5");
        push(8'(ca >> 16), 0, 0, 0, "R5");
        push(8'(ca >> 8), 0, 0, 0, "R5");
        push(8'(ca), 0, 0, 0, "R5");
        n = 256 - int'(ca % 256);
        if (n > rem) n = rem;
        for (int i = 0; i < n; i++) begin
          push(dat(kidx), i == n - 1, 0, 1, "R1");
          kidx++;
        end
        push(8'h04, 1, 0, 0, "R3");
        mbusy = BUSY;
        ca += n; rem -= n;
      end
      if (br) begin mpoll(); push(8'hE9, 1, 0, 0, "R6"); end
      if (hi) begin mpoll(); push(8'hC2, 0, 0, 0, "R7"); push(8'h00, 1, 0, 0, "R7"); end
      base += seglen; left -= int'(seglen);
    end
  endtask

  always @(negedge clk) begin
    logic [10:0] e;
    string t;
    cyc++;
    if (cyc > 190000) begin
      chk(0, "R10", "watchdog expired", cyc, 0);
      summary();
    end
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    m_ready  = lfsr[0] | lfsr[3];
    wr_valid = lfsr[5] | lfsr[7];
    wr_data  = dat(didx);
    r_valid  = 1'b0;
    if (rsp_cd > 0) begin
      rsp_cd--;
      if (rsp_cd == 0) begin
        r_valid = 1'b1;
        r_byte  = (stuck || fbusy > 0) ? 8'h9F : 8'h02;
        if (fbusy > 0 && !stuck) fbusy--;
      end
    end
    #1;
    if (rst_n) begin
      if (wr_ready && !(exp_q.size() > 0 && exp_q[0][10]))
        chk(0, "R9", "wr_ready outside data", 1, 0);
      if (wr_valid && wr_ready) didx++;
      if (m_valid && m_ready) begin
        if (exp_q.size() == 0) chk(0, "R10", "unexpected byte", m_byte, 0);
        else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk({m_rd, m_last, m_byte} == e[9:0], t, "byte {rd,last,byte}",
              {m_rd, m_last, m_byte}, e[9:0]);
          if (m_rd) rsp_cd = 2;
          if (!e[10] && e[7:0] == 8'h04 && e[8]) fbusy = BUSY;
        end
      end
      if (done) begin
        done_seen = 1'b1;
        chk(exp_q.size() == 0, exp_err ? "R11" : "R10", "done with bytes pending", exp_q.size(), 0);
        chk(err == exp_err, exp_err ? "R11" : "R10", "err flag", err, exp_err);
      end
    end
  end

  task automatic run(string tag, logic [31:0] a, int len, logic [1:0] am, bit q, bit stk);
    int w;
    kidx = 0; didx = 0; done_seen = 1'b0; exp_err = stk;
    if (stk) begin
      stuck = 1'b1;
      repeat (PM) push(8'h05, 1, 1, 0, "R11");
      mbusy = 0;
    end else gen(a, len, am, q);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_len = 16'(len); cfg_amode = am; cfg_quad = q;
    @(negedge clk);
    req_valid = 1'b0;
    w = 0;
    while (!done_seen && w < 40000) begin @(negedge clk); w++; end
    chk(done_seen, tag, "request completion", done_seen, 1);
    if (len == 0) chk(w <= 1, "R8", "zero length latency", w, 1);
    #2;
    chk(exp_q.size() == 0 && !m_valid, tag, "stream fully consumed", exp_q.size(), 0);
    exp_q.delete(); tag_q.delete();
    if (stk) begin stuck = 1'b0; fbusy = 0; mbusy = 0; end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(!m_valid && !done && !wr_ready, "R10", "quiet in reset", m_valid, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #1;
    chk(req_ready && !m_valid && !done, "R10", "idle after reset", req_ready, 1);
    run("R1", 32'h0000_0010, 20, 2'd0, 1'b0, 1'b0);
    run("R1", 32'h0000_00F0, 300, 2'd0, 1'b0, 1'b0);
    run("R5", 32'h0012_34FE, 5, 2'd1, 1'b0, 1'b0);
    run("R6", 32'h00FF_FFF0, 40, 2'd2, 1'b0, 1'b0);
    run("R5", 32'h0000_0100, 10, 2'd2, 1'b0, 1'b0);
    run("R4", 32'h0000_0080, 8, 2'd0, 1'b1, 1'b0);
    run("R7", 32'h01FF_FFFA, 12, 2'd3, 1'b0, 1'b0);
    run("R7", 32'h0200_0100, 4, 2'd3, 1'b0, 1'b0);
    run("R8", 32'h0000_0040, 0, 2'd0, 1'b0, 1'b0);
    run("R11", 32'h0000_0000, 4, 2'd0, 1'b0, 1'b1);
    repeat (4) @(negedge clk);
    run("R12", 32'h0003_01FD, 9, 2'd0, 1'b0, 1'b0);
    summary();
  end
endmodule